// File: doc/BRIEF.md
# NAND Asynchronous Data Phase Sequencer

This block runs the data phase of one asynchronous NAND access. A request names one of eight chip selects and says whether it is a read or a write. The host raises the request on a hit to that chip select's data-port location or on an access anywhere in that chip select's memory window. Both kinds of hit produce the same request. When the request is accepted, a 5-bit cycle counter starts at zero and advances once per clock. Each strobe edge is set by a programmable cycle count compared against that counter.

On a read, the block drives chip select and read enable and leaves the data bus tri-stated. It captures the 16-bit bus at its own programmable capture cycle. That cycle may come after read enable has gone high, so the NAND's hold time after read enable can be used to shorten the access. On a write, the block drives chip select and write enable, and it drives the write data onto the bus. Each access ends with a one-cycle done pulse. For a read, the captured word is presented with that pulse. The timing inputs must stay stable while an access is in progress.

Top module: `nand_data_seq`

## Requirements
- R1: When `busy` is low, a `req_valid` seen at a clock edge starts an access: `busy` rises and the counter is 0 in the next cycle. A `req_valid` seen while `busy` is high is ignored and changes neither the strobes, the chip-select index nor the data of the running access.
- R2: On a read, bit `req_cs` of `nand_cs_n` is low exactly while the counter value c satisfies `t_cs_on` <= c < `t_cs_rd_off`.
- R3: On a read, `nand_re_n` is low exactly while `t_re_on` <= c < `t_re_off`.
- R4: On a read, the bus value present while c equals `t_rd_cap` is captured. This holds even when that cycle falls after read enable has deasserted. The captured word appears on `rd_data` in the cycle where `done` is high.
- R5: On a write, bit `req_cs` of `nand_cs_n` is low exactly while `t_cs_on` <= c < `t_cs_wr_off`.
- R6: On a write, `nand_we_n` is low exactly while `t_we_on` <= c < `t_we_off`.
- R7: During a read, `nand_we_n` stays high. During a write, `nand_re_n` stays high. `nand_ale` and `nand_cle` are always low.
- R8: An access stays busy while c runs from 0 up to its cycle count (`t_rd_cycle` for a read, `t_wr_cycle` for a write). In the next cycle `busy` is low and `done` is high for exactly one cycle. A new request may be accepted in that same cycle.
- R9: During a write, `nand_d_oe` is high and `nand_d_out` carries the request's write data while `t_cs_on` <= c <= `t_wr_cycle`. During a read, `nand_d_oe` stays low.
- R10: A strobe whose ON count is equal to or greater than its OFF count does not assert at any point in the access.
- R11: At most one bit of `nand_cs_n` is low at any time, and it is always the bit of the chip select that was requested.
- R12: After reset and whenever the block is idle, every `nand_cs_n` bit, `nand_re_n` and `nand_we_n` are high, and `nand_d_oe`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request (data-port or window hit) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Chip-select index 0..7 |
| req_wdata | input | 16 | Write data |
| t_cs_on | input | 5 | Chip-select assert cycle |
| t_cs_rd_off | input | 5 | Chip-select deassert cycle, read |
| t_cs_wr_off | input | 5 | Chip-select deassert cycle, write |
| t_re_on | input | 5 | Read-enable assert cycle |
| t_re_off | input | 5 | Read-enable deassert cycle |
| t_we_on | input | 5 | Write-enable assert cycle |
| t_we_off | input | 5 | Write-enable deassert cycle |
| t_rd_cap | input | 5 | Read capture cycle |
| t_rd_cycle | input | 5 | Last counter value of a read |
| t_wr_cycle | input | 5 | Last counter value of a write |
| nand_d_in | input | 16 | Data bus input |
| nand_d_out | output | 16 | Data bus output value |
| nand_d_oe | output | 1 | Data bus output enable |
| nand_cs_n | output | 8 | Chip selects, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_ale | output | 1 | Address latch enable (held low) |
| nand_cle | output | 1 | Command latch enable (held low) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read word |

## Verification
The first read uses the usual profile: chip select and read enable both start at cycle 0, and chip select lasts the whole cycle. Its capture falls after read enable has risen. This separates a capture keyed to the capture count from one keyed to the read-enable edge. A second read delays every edge and captures early, which exposes mixed-up ON/OFF operands and swapped chip-select indices. The bus input changes every cycle, so a capture taken one cycle off returns the wrong word. Writes check separately that the write OFF count is used rather than the read one, and that the bus is driven only from chip-select ON to the end of the cycle. A request raised in the middle of a write tells a block that ignores it apart from one that restarts or switches chip select. Accesses with ON >= OFF, and a request accepted in the done cycle, cover the empty-window and back-to-back cases.

// File: rtl/nand_data_seq.sv
module nand_data_seq #(
  parameter int DW  = 16,
  parameter int NCS = 8,
  parameter int TW  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [$clog2(NCS)-1:0] req_cs,
  input  logic [DW-1:0]          req_wdata,
  input  logic [TW-1:0]          t_cs_on,
  input  logic [TW-1:0]          t_cs_rd_off,
  input  logic [TW-1:0]          t_cs_wr_off,
  input  logic [TW-1:0]          t_re_on,
  input  logic [TW-1:0]          t_re_off,
  input  logic [TW-1:0]          t_we_on,
  input  logic [TW-1:0]          t_we_off,
  input  logic [TW-1:0]          t_rd_cap,
  input  logic [TW-1:0]          t_rd_cycle,
  input  logic [TW-1:0]          t_wr_cycle,
  input  logic [DW-1:0]          nand_d_in,
  output logic [DW-1:0]          nand_d_out,
  output logic                   nand_d_oe,
  output logic [NCS-1:0]         nand_cs_n,
  output logic                   nand_re_n,
  output logic                   nand_we_n,
  output logic                   nand_ale,
  output logic                   nand_cle,
  output logic                   busy,
  output logic                   done,
  output logic [DW-1:0]          rd_data
);
  localparam int CSW = $clog2(NCS);

  logic           busy_q, wr_q, done_q;
  logic [TW-1:0]  cnt_q;
  logic [CSW-1:0] cs_q;
  logic [DW-1:0]  wdat_q, rdat_q;

  function automatic logic in_win(logic [TW-1:0] c, logic [TW-1:0] on, logic [TW-1:0] off);
    return (on < off) && (c >= on) && (c < off);
  endfunction

  wire [TW-1:0] cs_off  = wr_q ? t_cs_wr_off : t_cs_rd_off;
  wire [TW-1:0] cyc_end = wr_q ? t_wr_cycle  : t_rd_cycle;
  wire          last    = busy_q && (cnt_q == cyc_end);
  wire          cs_act  = busy_q && in_win(cnt_q, t_cs_on, cs_off);
  wire          re_act  = busy_q && !wr_q && in_win(cnt_q, t_re_on, t_re_off);
  wire          we_act  = busy_q &&  wr_q && in_win(cnt_q, t_we_on, t_we_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cs_q   <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      done_q <= last;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          wr_q   <= req_write;
          cs_q   <= req_cs;
          wdat_q <= req_wdata;
          cnt_q  <= '0;
        end
      end else if (last) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (busy_q && !wr_q && cnt_q == t_rd_cap)
        rdat_q <= nand_d_in;
    end
  end

  assign nand_cs_n  = ~({{(NCS-1){1'b0}}, cs_act} << cs_q);
  assign nand_re_n  = ~re_act;
  assign nand_we_n  = ~we_act;
  assign nand_ale   = 1'b0;
  assign nand_cle   = 1'b0;
  assign nand_d_oe  = busy_q && wr_q && (cnt_q >= t_cs_on);
  assign nand_d_out = wdat_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign rd_data    = rdat_q;
endmodule

module nand_data_seq_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           busy,
  input logic           done,
  input logic [NCS-1:0] nand_cs_n,
  input logic           nand_re_n,
  input logic           nand_we_n,
  input logic           nand_d_oe
);
  a_r1_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));
  a_r9_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    nand_d_oe |-> nand_re_n);
  a_r11_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_cs_n));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&nand_cs_n && nand_re_n && nand_we_n && !nand_d_oe));
endmodule

bind nand_data_seq nand_data_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .nand_cs_n(nand_cs_n), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
  .nand_d_oe(nand_d_oe)
);

// File: tb/nand_data_seq_bench.sv
module nand_data_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [2:0]  req_cs = 0;
  logic [15:0] req_wdata = 0, d_in = 0;
  logic [4:0]  cs_on = 0, cs_rd_off = 0, cs_wr_off = 0, re_on = 0, re_off = 0;
  logic [4:0]  we_on = 0, we_off = 0, rd_cap = 0, rd_cyc = 0, wr_cyc = 0;
  logic [15:0] d_out, rd_data;
  logic [7:0]  cs_n;
  logic        d_oe, re_n, we_n, ale, cle, busy, done;

  nand_data_seq u_nand_data_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_wdata(req_wdata), .t_cs_on(cs_on),
    .t_cs_rd_off(cs_rd_off), .t_cs_wr_off(cs_wr_off), .t_re_on(re_on),
    .t_re_off(re_off), .t_we_on(we_on), .t_we_off(we_off), .t_rd_cap(rd_cap),
    .t_rd_cycle(rd_cyc), .t_wr_cycle(wr_cyc), .nand_d_in(d_in),
    .nand_d_out(d_out), .nand_d_oe(d_oe), .nand_cs_n(cs_n), .nand_re_n(re_n),
    .nand_we_n(we_n), .nand_ale(ale), .nand_cle(cle), .busy(busy),
    .done(done), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [10:0] seed = 0;
  logic [16:0] exp_q[$];
  logic [15:0] last_dout = 0;
  int re_low = 0, we_low = 0;

  bit m_busy = 0, m_wr = 0, m_done = 0;
  logic [4:0]  m_cnt = 0;
  logic [2:0]  m_cs = 0;
  logic [15:0] m_wd = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(logic [4:0] c, logic [4:0] on, logic [4:0] off);
    return on < off && c >= on && c < off;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; m_cnt = 0; m_wr = req_write; m_cs = req_cs; m_wd = req_wdata;
        end
      end else if (m_cnt == (m_wr ? wr_cyc : rd_cyc)) begin
        m_busy = 0; m_done = 1;
      end else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] e_cs;
      bit e_cs_act, e_re, e_we, e_oe;
      logic [16:0] item;
      e_cs_act = m_busy && win(m_cnt, cs_on, m_wr ? cs_wr_off : cs_rd_off);
      e_cs = e_cs_act ? ~(8'd1 << m_cs) : 8'hFF;
      e_re = m_busy && !m_wr && win(m_cnt, re_on, re_off);
      e_we = m_busy && m_wr && win(m_cnt, we_on, we_off);
      e_oe = m_busy && m_wr && m_cnt >= cs_on;
      check(cs_n == e_cs, m_wr ? "R5 R11 cs_n" : "R2 R11 cs_n", cs_n, e_cs);
      check(re_n == !e_re, m_wr ? "R7 re_n during write" : "R3 re_n", re_n, !e_re);
      check(we_n == !e_we, m_wr ? "R6 we_n" : "R7 we_n during read", we_n, !e_we);
      check(!ale && !cle, "R7 ale/cle", {ale, cle}, 0);
      check(d_oe == e_oe, "R9 d_oe", d_oe, e_oe);
      if (e_oe) check(d_out == m_wd, "R9 d_out", d_out, m_wd);
      check(busy == m_busy, "R1 R8 busy", busy, m_busy);
      check(done == m_done, "R8 done", done, m_done);
      if (!re_n) re_low++;
      if (!we_n) we_low++;
      if (d_oe) last_dout = d_out;
      if (done && exp_q.size() > 0) begin
        item = exp_q.pop_front();
        if (item[16]) check(last_dout == item[15:0], "R9 written word", last_dout, item[15:0]);
        else check(rd_data == item[15:0], "R4 captured word", rd_data, item[15:0]);
      end
      d_in = {seed, m_cnt};
    end
  end

  task automatic access(input bit wr, input logic [2:0] cs, input logic [15:0] wd);
    if (!wr && re_on >= re_off) $display("note: configuration error, read enable ON >= OFF");
    if (wr && we_on >= we_off) $display("note: configuration error, write enable ON >= OFF");
    if (cs_on >= (wr ? cs_wr_off : cs_rd_off)) $display("note: configuration error, chip select ON >= OFF");
    req_valid = 1; req_write = wr; req_cs = cs; req_wdata = wd;
    exp_q.push_back(wr ? {1'b1, wd} : {1'b0, seed, rd_cap});
    re_low = 0; we_low = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 8'hFF && re_n && we_n && !d_oe && !busy && !done, "R12 reset state",
          {cs_n, re_n, we_n, d_oe, busy, done}, {8'hFF, 5'b11000});
    rst_n = 1;
    @(negedge clk);
    // typical read: capture after read enable rises
    cs_on = 0; re_on = 0; re_off = 4; rd_cap = 5; rd_cyc = 6; cs_rd_off = 6; seed = 11'h2A5;
    access(0, 3, 0);
    // delayed edges, early capture
    cs_on = 1; re_on = 2; re_off = 7; rd_cap = 3; rd_cyc = 9; cs_rd_off = 8; seed = 11'h155;
    access(0, 0, 0);
    // write, with a stray request mid-access (R1)
    cs_on = 1; we_on = 2; we_off = 5; cs_wr_off = 6; wr_cyc = 7; cs_rd_off = 3;
    req_valid = 1; req_write = 1; req_cs = 7; req_wdata = 16'hBEEF;
    exp_q.push_back({1'b1, 16'hBEEF});
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    req_valid = 1; req_write = 0; req_cs = 2; req_wdata = 16'h1234;
    @(negedge clk);
    req_valid = 0;
    while (m_busy) @(negedge clk);
    // config error: read enable ON > OFF (R10)
    cs_on = 0; re_on = 5; re_off = 3; rd_cap = 2; rd_cyc = 5; cs_rd_off = 5; seed = 11'h0F0;
    access(0, 5, 0);
    check(re_low == 0, "R10 read enable never low", re_low, 0);
    // config error: write enable ON == OFF (R10), then back-to-back read in done cycle
    we_on = 3; we_off = 3; cs_wr_off = 4; wr_cyc = 4;
    access(1, 1, 16'h5A5A);
    check(we_low == 0, "R10 write enable never low", we_low, 0);
    check(done, "R8 done before back-to-back", done, 1);
    cs_on = 0; re_on = 1; re_off = 3; rd_cap = 4; rd_cyc = 4; cs_rd_off = 4; seed = 11'h3C3;
    access(0, 6, 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 R8 all accesses completed", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule